// File: doc/BRIEF.md
# Interrupt Source Selector

This unit sits between the instruction sequencer of a processor core and the sources that can divert execution into a service routine. At every instruction boundary the sequencer raises a one-cycle `boundary` strobe. The block then looks at everything pending at that moment and picks a single winner. The candidates are a divide fault, software interrupt instructions (with an immediate type, the one-byte breakpoint, and interrupt-on-overflow), a latched non-maskable request, the maskable request line gated by the interrupt-enable flag, and the trap flag. The winner's type number is handed to the entry sequencer through a one-cycle `req_valid` strobe.

Most sources map to a fixed type number:

| Source | Type |
|---|---|
| Divide fault | 0 |
| Single step | 1 |
| Non-maskable request | 2 |
| Breakpoint | 3 |
| Overflow trap | 4 |

A software interrupt passes its immediate through as the type. A maskable request gets its type from an external controller. The block pulses `inta` for one cycle and samples `ack_vector` in the cycle that follows, then presents that byte as the type. Boundaries that arrive while this handshake is in progress are not acted upon.

Top module: `int_source_select`

## Requirements
- R1: After reset `req_valid` and `inta` are 0. A non-maskable input that is already high when reset is released counts as no edge and raises no request.
- R2: A divide fault at a boundary yields type 0 one cycle later. Among the instruction-caused sources the order is divide fault, then software interrupt, then breakpoint, then overflow trap.
- R3: A software interrupt at a boundary yields, one cycle later, a request whose type equals the 8-bit immediate, for every immediate value. The breakpoint strobe yields type 3.
- R4: The overflow-trap strobe yields type 4 when the overflow flag is 1. When the flag is 0 it raises nothing, and lower-priority sources are considered as if it were absent.
- R5: A rising edge on the non-maskable input is latched until a boundary selects it, whatever the interrupt-enable flag, and yields type 2. One edge produces exactly one request, even if the level stays high.
- R6: The maskable request line is ignored while the interrupt-enable flag is 0: no `inta`, no request.
- R7: A selected maskable request drives `inta` high for exactly the one cycle after the boundary. The byte on `ack_vector` in the next cycle is captured. The request with that type appears the cycle after that.
- R8: With only the trap flag set, a boundary yields type 1.
- R9: The priority is: instruction-caused sources, then the latched non-maskable request, then the maskable line, then single step. A non-maskable edge that loses stays pending and is served at a later boundary.
- R10: A boundary that arrives while the acknowledge handshake is in progress produces no request of its own.
- R11: Without a boundary strobe no request and no `inta` are produced, whatever the sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction boundary strobe |
| nmi_in | input | 1 | Non-maskable request input, rising edge detected |
| intr_in | input | 1 | Maskable request line, level |
| ien_flag | input | 1 | Interrupt-enable flag |
| step_flag | input | 1 | Trap (single-step) flag |
| ovf_flag | input | 1 | Overflow flag |
| div_fault | input | 1 | Divide fault from the divider |
| sw_int | input | 1 | Software interrupt instruction with immediate |
| sw_int3 | input | 1 | One-byte breakpoint instruction |
| sw_into | input | 1 | Interrupt-on-overflow instruction |
| sw_imm | input | 8 | Immediate type of the software interrupt |
| ack_vector | input | 8 | Type byte from the external controller |
| req_valid | output | 1 | One-cycle strobe: a type is selected |
| req_type | output | 8 | Selected type number |
| inta | output | 1 | Acknowledge pulse toward the external controller |

## Verification
A wrong priority decode shows at once as a wrong `req_type` one cycle after the boundary, so the bench sweeps all combinations of the four priority classes. A corrupted non-maskable latch is slower to show. A lost edge appears as a missing type 2 at the next quiet boundary, and a stuck latch appears as a duplicate type 2 there. The bench therefore drains after each mixed case. A handshake state that is off by one shows within three cycles: the captured type no longer matches the byte driven in the cycle after `inta`, or a boundary raised during the handshake leaks a request.

// File: rtl/iss_pkg.sv
package iss_pkg;

   typedef enum logic [2:0] {
      SRC_NONE,
      SRC_DIV,
      SRC_SWINT,
      SRC_BRK,
      SRC_INTO,
      SRC_NMI,
      SRC_INTR,
      SRC_STEP
   } src_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_ACK,
      S_CAPT
   } ack_state_e;

endpackage

// File: rtl/iss_nmi_latch.sv
module iss_nmi_latch #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_in,
   input  logic clear,
   output logic pending
);

   logic nmi_s;
   logic nmi_prev;
   logic rise;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign nmi_s = nmi_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               chain <= '1;
            end else begin
               chain[0] <= nmi_in;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  chain[i] <= chain[i-1];
               end
            end
         end
         assign nmi_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   assign rise = nmi_s & ~nmi_prev;

   // prev resets high: a level present at reset release is not an edge (R1)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nmi_prev <= 1'b1;
         pending  <= 1'b0;
      end else begin
         nmi_prev <= nmi_s;
         pending  <= rise | (pending & ~clear);
      end
   end

   initial begin
      p_sync_range: assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
         else $error("SYNC_STAGES out of range");
   end

   p_edge_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> pending);
   p_hold_until_served_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !clear) |=> pending);
   p_served_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !rise) |=> !pending);

endmodule

// File: rtl/iss_arbiter.sv
module iss_arbiter
   import iss_pkg::*;
#(
   parameter int TYPE_W    = 8,
   parameter int DIV_TYPE  = 0,
   parameter int STEP_TYPE = 1,
   parameter int NMI_TYPE  = 2,
   parameter int BRK_TYPE  = 3,
   parameter int OVF_TYPE  = 4
) (
   input  logic              div_fault,
   input  logic              sw_int,
   input  logic              sw_int3,
   input  logic              sw_into,
   input  logic [TYPE_W-1:0] sw_imm,
   input  logic              ovf_flag,
   input  logic              nmi_pend,
   input  logic              intr_in,
   input  logic              ien_flag,
   input  logic              step_flag,
   output src_e              kind,
   output logic [TYPE_W-1:0] fixed_type
);

   localparam logic [TYPE_W-1:0] T_DIV  = DIV_TYPE[TYPE_W-1:0];
   localparam logic [TYPE_W-1:0] T_STEP = STEP_TYPE[TYPE_W-1:0];
   localparam logic [TYPE_W-1:0] T_NMI  = NMI_TYPE[TYPE_W-1:0];
   localparam logic [TYPE_W-1:0] T_BRK  = BRK_TYPE[TYPE_W-1:0];
   localparam logic [TYPE_W-1:0] T_OVF  = OVF_TYPE[TYPE_W-1:0];

   // fixed order: instruction-caused, NMI, INTR, single step (R9)
   always_comb begin
      kind       = SRC_NONE;
      fixed_type = '0;
      if (div_fault) begin
         kind       = SRC_DIV;
         fixed_type = T_DIV;
      end else if (sw_int) begin
         kind       = SRC_SWINT;
         fixed_type = sw_imm;
      end else if (sw_int3) begin
         kind       = SRC_BRK;
         fixed_type = T_BRK;
      end else if (sw_into && ovf_flag) begin
         kind       = SRC_INTO;
         fixed_type = T_OVF;
      end else if (nmi_pend) begin
         kind       = SRC_NMI;
         fixed_type = T_NMI;
      end else if (intr_in && ien_flag) begin
         kind       = SRC_INTR;
      end else if (step_flag) begin
         kind       = SRC_STEP;
         fixed_type = T_STEP;
      end
   end

   initial begin
      p_types_fit: assert (TYPE_W >= 3 && DIV_TYPE < (1 << TYPE_W) &&
                           STEP_TYPE < (1 << TYPE_W) && NMI_TYPE < (1 << TYPE_W) &&
                           BRK_TYPE < (1 << TYPE_W) && OVF_TYPE < (1 << TYPE_W))
         else $error("fixed type numbers do not fit TYPE_W");
   end

   always_comb begin
      if (kind == SRC_INTR) begin
         p_intr_masked_r6: assert (ien_flag);
      end
      if (kind == SRC_STEP) begin
         p_step_lowest_r9: assert (!nmi_pend && !div_fault && !sw_int && !sw_int3);
      end
   end

endmodule

// File: rtl/iss_ack_fsm.sv
module iss_ack_fsm
   import iss_pkg::*;
#(
   parameter int TYPE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary,
   input  src_e              kind,
   input  logic [TYPE_W-1:0] fixed_type,
   input  logic [TYPE_W-1:0] ack_vector,
   output logic              req_valid,
   output logic [TYPE_W-1:0] req_type,
   output logic              inta,
   output logic              idle
);

   ack_state_e st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         req_valid <= 1'b0;
         req_type  <= '0;
      end else begin
         req_valid <= 1'b0;
         case (st)
            S_IDLE: begin
               if (boundary) begin
                  if (kind == SRC_INTR) begin
                     st <= S_ACK;
                  end else if (kind != SRC_NONE) begin
                     req_valid <= 1'b1;
                     req_type  <= fixed_type;
                  end
               end
            end
            S_ACK: st <= S_CAPT;
            S_CAPT: begin
               st        <= S_IDLE;
               req_valid <= 1'b1;
               req_type  <= ack_vector;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign inta = (st == S_ACK);
   assign idle = (st == S_IDLE);

   p_inta_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      inta |=> !inta);
   p_vector_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      inta |=> ##1 (req_valid && req_type == $past(ack_vector)));
   p_no_req_during_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      inta |-> !req_valid);
   p_req_needs_boundary_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ($past(boundary) || $past(st) == S_CAPT));

endmodule

// File: rtl/int_source_select.sv
module int_source_select
   import iss_pkg::*;
#(
   parameter int TYPE_W          = 8,
   parameter int NMI_SYNC_STAGES = 0,
   parameter int DIV_TYPE        = 0,
   parameter int STEP_TYPE       = 1,
   parameter int NMI_TYPE        = 2,
   parameter int BRK_TYPE        = 3,
   parameter int OVF_TYPE        = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary,
   input  logic              nmi_in,
   input  logic              intr_in,
   input  logic              ien_flag,
   input  logic              step_flag,
   input  logic              ovf_flag,
   input  logic              div_fault,
   input  logic              sw_int,
   input  logic              sw_int3,
   input  logic              sw_into,
   input  logic [TYPE_W-1:0] sw_imm,
   input  logic [TYPE_W-1:0] ack_vector,
   output logic              req_valid,
   output logic [TYPE_W-1:0] req_type,
   output logic              inta
);

   logic              nmi_pend;
   logic              nmi_take;
   logic              idle;
   src_e              kind;
   logic [TYPE_W-1:0] fixed_type;

   assign nmi_take = boundary & idle & (kind == SRC_NMI);

   iss_nmi_latch #(
      .SYNC_STAGES(NMI_SYNC_STAGES)
   ) u_nmi (
      .clk    (clk),
      .rst_n  (rst_n),
      .nmi_in (nmi_in),
      .clear  (nmi_take),
      .pending(nmi_pend)
   );

   iss_arbiter #(
      .TYPE_W   (TYPE_W),
      .DIV_TYPE (DIV_TYPE),
      .STEP_TYPE(STEP_TYPE),
      .NMI_TYPE (NMI_TYPE),
      .BRK_TYPE (BRK_TYPE),
      .OVF_TYPE (OVF_TYPE)
   ) u_arb (
      .div_fault (div_fault),
      .sw_int    (sw_int),
      .sw_int3   (sw_int3),
      .sw_into   (sw_into),
      .sw_imm    (sw_imm),
      .ovf_flag  (ovf_flag),
      .nmi_pend  (nmi_pend),
      .intr_in   (intr_in),
      .ien_flag  (ien_flag),
      .step_flag (step_flag),
      .kind      (kind),
      .fixed_type(fixed_type)
   );

   iss_ack_fsm #(
      .TYPE_W(TYPE_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .boundary  (boundary),
      .kind      (kind),
      .fixed_type(fixed_type),
      .ack_vector(ack_vector),
      .req_valid (req_valid),
      .req_type  (req_type),
      .inta      (inta),
      .idle      (idle)
   );

   p_nmi_beats_intr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && idle && nmi_pend && !div_fault && !sw_int && !sw_int3)
         |=> (req_valid || !inta));

endmodule

// File: tb/tb_int_source_select.sv
module tb_int_source_select;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       boundary = 1'b0;
   logic       nmi_in = 1'b0;
   logic       intr_in = 1'b0;
   logic       ien_flag = 1'b0;
   logic       step_flag = 1'b0;
   logic       ovf_flag = 1'b0;
   logic       div_fault = 1'b0;
   logic       sw_int = 1'b0;
   logic       sw_int3 = 1'b0;
   logic       sw_into = 1'b0;
   logic [7:0] sw_imm = 8'h00;
   logic [7:0] ack_vector = 8'h00;
   logic       req_valid;
   logic [7:0] req_type;
   logic       inta;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   int_source_select dut (
      .clk(clk), .rst_n(rst_n), .boundary(boundary), .nmi_in(nmi_in),
      .intr_in(intr_in), .ien_flag(ien_flag), .step_flag(step_flag),
      .ovf_flag(ovf_flag), .div_fault(div_fault), .sw_int(sw_int),
      .sw_int3(sw_int3), .sw_into(sw_into), .sw_imm(sw_imm),
      .ack_vector(ack_vector), .req_valid(req_valid), .req_type(req_type),
      .inta(inta)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_src();
      intr_in = 0; ien_flag = 0; step_flag = 0; ovf_flag = 0;
      div_fault = 0; sw_int = 0; sw_int3 = 0; sw_into = 0; sw_imm = 0;
   endtask

   // boundary held for one cycle; returns at the negedge after the sampling edge
   task automatic fire();
      boundary = 1;
      @(negedge clk);
      boundary = 0;
      clear_src();
   endtask

   task automatic expect_req(input string tag, input logic v, input logic [7:0] t);
      chk({tag, " req_valid"}, req_valid, v);
      chk({tag, " inta"}, inta, 1'b0);
      if (v) chk({tag, " req_type"}, req_type, t);
   endtask

   // called right after fire() selected the maskable line
   task automatic ack_handshake(input string tag, input logic [7:0] vec, input bit poke);
      chk({tag, " inta high"}, inta, 1'b1);
      chk({tag, " no req in ack"}, req_valid, 1'b0);
      ack_vector = ~vec;
      if (poke) begin
         boundary = 1; sw_int = 1; sw_imm = 8'h99;
      end
      @(negedge clk);
      boundary = 0; clear_src();
      chk({tag, " inta single"}, inta, 1'b0);
      chk({tag, " no req yet"}, req_valid, 1'b0);
      ack_vector = vec;
      @(negedge clk);
      ack_vector = 8'h00;
      chk({tag, " vector req"}, req_valid, 1'b1);
      chk({tag, " vector type"}, req_type, {24'd0, vec});
      @(negedge clk);
      chk({tag, " no extra req"}, req_valid, 1'b0);
      chk({tag, " no extra inta"}, inta, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1: reset state, NMI high across reset release is not an edge
      nmi_in = 1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      chk("R1 req after reset", req_valid, 1'b0);
      chk("R1 inta after reset", inta, 1'b0);
      fire();
      expect_req("R1 level at release", 1'b0, 8'h00);
      nmi_in = 0;
      @(negedge clk);

      // R3: every immediate passes through
      for (int v = 0; v < 256; v++) begin
         sw_int = 1; sw_imm = v[7:0];
         fire();
         expect_req("R3 imm", 1'b1, v[7:0]);
      end
      sw_int3 = 1; fire(); expect_req("R3 breakpoint", 1'b1, 8'd3);

      // R4: overflow trap
      sw_into = 1; ovf_flag = 1; fire(); expect_req("R4 of=1", 1'b1, 8'd4);
      sw_into = 1; ovf_flag = 0; fire(); expect_req("R4 of=0", 1'b0, 8'd0);
      sw_into = 1; ovf_flag = 0; step_flag = 1; fire(); expect_req("R4 of=0 falls through", 1'b1, 8'd1);

      // R2: divide fault and instruction sub-order
      div_fault = 1; fire(); expect_req("R2 divide", 1'b1, 8'd0);
      div_fault = 1; sw_int = 1; sw_imm = 8'h55; sw_int3 = 1; fire();
      expect_req("R2 divide wins", 1'b1, 8'd0);
      sw_int = 1; sw_imm = 8'h21; sw_int3 = 1; sw_into = 1; ovf_flag = 1; fire();
      expect_req("R2 int over int3", 1'b1, 8'h21);
      sw_int3 = 1; sw_into = 1; ovf_flag = 1; fire();
      expect_req("R2 int3 over into", 1'b1, 8'd3);

      // R8: single step
      step_flag = 1; fire(); expect_req("R8 step", 1'b1, 8'd1);

      // R11: sources without boundary
      div_fault = 1; sw_int = 1; step_flag = 1; intr_in = 1; ien_flag = 1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R11 no req", req_valid, 1'b0);
         chk("R11 no inta", inta, 1'b0);
      end
      clear_src();

      // R5: one request per edge, unmasked by IF
      nmi_in = 1; @(negedge clk); nmi_in = 0;
      ien_flag = 0; fire(); expect_req("R5 nmi if=0", 1'b1, 8'd2);
      fire(); expect_req("R5 only once", 1'b0, 8'd0);
      nmi_in = 1; @(negedge clk);
      fire(); expect_req("R5 held level", 1'b1, 8'd2);
      fire(); expect_req("R5 held no repeat", 1'b0, 8'd0);
      nmi_in = 0; @(negedge clk);

      // R6: masked INTR
      intr_in = 1; ien_flag = 0; fire();
      expect_req("R6 masked", 1'b0, 8'd0);
      @(negedge clk);
      chk("R6 masked later inta", inta, 1'b0);
      chk("R6 masked later req", req_valid, 1'b0);

      // R7: acknowledge handshake over several vectors
      for (int j = 0; j < 8; j++) begin
         intr_in = 1; ien_flag = 1; fire();
         ack_handshake("R7", 8'((j * 37) ^ 8'hA5), 1'b0);
      end
      // R10: boundary during handshake is ignored
      intr_in = 1; ien_flag = 1; fire();
      ack_handshake("R10", 8'h48, 1'b1);

      // R9: all combinations of div / nmi / intr / step
      for (int m = 0; m < 16; m++) begin
         if (m[1]) begin
            nmi_in = 1; @(negedge clk); nmi_in = 0;
         end
         div_fault = m[0]; intr_in = m[2]; ien_flag = m[2]; step_flag = m[3];
         fire();
         if (m[0])      expect_req("R9 div", 1'b1, 8'd0);
         else if (m[1]) expect_req("R9 nmi", 1'b1, 8'd2);
         else if (m[2]) ack_handshake("R9 intr", 8'(8'h20 + m), 1'b0);
         else if (m[3]) expect_req("R9 step", 1'b1, 8'd1);
         else           expect_req("R9 none", 1'b0, 8'd0);
         if (m[0] && m[1]) begin
            fire(); expect_req("R9 nmi kept pending", 1'b1, 8'd2);
         end
         fire(); expect_req("R9 drained", 1'b0, 8'd0);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule